// File: doc/BRIEF.md
# Sampling Tap Delay Tuning Engine

This block chooses the receive sampling tap for a high-speed SD bus. On a start request in a mode that needs tuning, it steps an 8-bit tap delay upward from zero and runs one tuning trial at each tap. A trial is a tuning-pattern block read, handed to an external command/data engine over a request/acknowledge handshake. The pass or fail result of every trial is kept in a one-bit-per-tap map.

After the sweep the engine scans the map for the longest stretch of consecutive passing taps. It places the final tap three quarters of the way into that stretch and runs one more trial there to confirm the choice. The tap is written into its field of a 32-bit clock-control word, and every other bit of that word passes through unchanged. Millisecond timeouts are counted from a prescaled system clock.

Top module: `tap_tune_engine`

## Requirements
- R1: A start in IDLE begins tuning only when `bus_mode` is 3'd3 (SDR104), or when it is 3'd2 (SDR50) and `sdr50_tune_req` is 1. In any other case `done` pulses on the cycle after start is sampled, `tune_err` is cleared, no trial is requested, and the tap keeps its value.
- R2: The sweep runs exactly one trial per tap, for taps 0, 1, ..., 254 in ascending order, then one confirming trial. The tap never changes while `trial_req` is high.
- R3: `clk_ctrl_out` carries the tap in bits 23:16. All other bits equal `clk_ctrl_in`.
- R4: `trial_req` is raised only after both `cmd_inhibit` and `dat_inhibit` were seen clear. If either inhibit stays set for INHIB_MS (10) ms, that trial fails without a request and without a line reset.
- R5: While `trial_req` is high, the trial fields read as follows: command index 19, `trial_cmd_flags` = 3'b111 (bit 0 short response, bit 1 CRC check, bit 2 data phase), 64-byte block and zero argument.
- R6: A trial passes only if `trial_ack` comes with `rsp_data_avail`=1, `rsp_crc_err`=0 and `rsp_tuned_ok`=1.
- R7: A requested trial that fails, either by its response or by receiving no `trial_ack` within POLL_MS (5) ms, produces a one-cycle pulse on both `rst_cmd_line` and `rst_dat_line` before the next trial.
- R8: `best_start`/`best_len` report the longest run of consecutive passing taps whose length is above 1. On equal lengths, the lower run is kept.
- R9: The final tap is `best_start + floor(3*best_len/4)`. If no qualifying run exists, the start and length are 0 and the final tap is 0.
- R10: The confirming trial runs at the final tap. Its failure sets `tune_err` when `done` pulses for one cycle.
- R11: After reset, `tap_out`, `done`, `trial_req`, `tune_err` and both line-reset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tuning request (sampled in IDLE) |
| bus_mode | input | 3 | Bus-speed mode code |
| sdr50_tune_req | input | 1 | SDR50 mode also needs tuning |
| cmd_inhibit | input | 1 | Command line busy |
| dat_inhibit | input | 1 | Data line busy |
| clk_ctrl_in | input | 32 | Current clock-control word |
| trial_ack | input | 1 | One-cycle trial completion |
| rsp_data_avail | input | 1 | Tuning block was received |
| rsp_crc_err | input | 1 | Data CRC error on the block |
| rsp_tuned_ok | input | 1 | Tuned-clock status confirmed |
| trial_req | output | 1 | Trial request, held until ack or timeout |
| trial_cmd_idx | output | 6 | Command index for the trial |
| trial_cmd_flags | output | 3 | Response/CRC/data flags |
| trial_blk_bytes | output | 12 | Read block size in bytes |
| trial_arg | output | 32 | Command argument |
| rst_cmd_line | output | 1 | Command-line reset pulse |
| rst_dat_line | output | 1 | Data-line reset pulse |
| tap_out | output | 8 | Current sampling tap |
| clk_ctrl_out | output | 32 | Clock-control word with the tap inserted |
| done | output | 1 | One-cycle completion pulse |
| best_start | output | 8 | First tap of the chosen run |
| best_len | output | 8 | Length of the chosen run |
| tune_err | output | 1 | Confirming trial failed |

## Verification
The properties assume that the command/data engine answers a request with at most one `trial_ack` pulse, and only while `trial_req` is high. They also assume that `start` is only meaningful in IDLE. The bench responder acknowledges each request exactly once, a few cycles after it rises, and never acknowledges when no request is pending. Inhibits are held steady for a whole run, so each trial meets the same inhibit condition. Responses are derived from the tap currently on `tap_out`, so the pass map the engine sees is exactly the one programmed for the case.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INH, ST_ACK, ST_LRST, ST_NEXT, ST_SCAN, ST_PLACE
  } tune_st_e;

  localparam logic [2:0]  MODE_SDR50     = 3'd2;
  localparam logic [2:0]  MODE_SDR104    = 3'd3;
  localparam logic [5:0]  TUNE_CMD_IDX   = 6'd19;
  localparam logic [2:0]  TUNE_CMD_FLAGS = 3'b111;
  localparam logic [11:0] TUNE_BLK_BYTES = 12'd64;
endpackage

// File: rtl/tune_ms_tick.sv
module tune_ms_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_d = '0;
      tick  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tune_result_map.sv
module tune_result_map #(
  parameter int N  = 255,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_val,
  output logic [N-1:0]  map
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map[g] <= 1'b0;
      else if (clr) map[g] <= 1'b0;
      else if (hit) map[g] <= wr_val;
    end
  end
endmodule

// File: rtl/tune_window_search.sv
module tune_window_search #(
  parameter int N = 255,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] map,
  output logic         fin,
  output logic [W-1:0] best_start,
  output logic [W-1:0] best_len
);
  logic         busy_q, busy_d;
  logic [W-1:0] idx_q, idx_d;
  logic [W-1:0] run_s_q, run_s_d, run_l_q, run_l_d;
  logic [W-1:0] bst_s_q, bst_s_d, bst_l_q, bst_l_d;
  logic         bit_here, at_end;

  // idx == N is a virtual failing tap that closes a run ending at N-1
  assign at_end   = (idx_q == W'(N));
  assign bit_here = at_end ? 1'b0 : map[idx_q];
  assign fin      = busy_q && at_end;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    run_s_d = run_s_q;
    run_l_d = run_l_q;
    bst_s_d = bst_s_q;
    bst_l_d = bst_l_q;
    if (go) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      run_l_d = '0;
      bst_s_d = '0;
      bst_l_d = '0;
    end else if (busy_q) begin
      if (bit_here) begin
        if (run_l_q == '0) run_s_d = idx_q;
        run_l_d = run_l_q + 1'b1;
      end else begin
        if ((run_l_q > bst_l_q) && (run_l_q > W'(1))) begin
          bst_s_d = run_s_q;
          bst_l_d = run_l_q;
        end
        run_l_d = '0;
      end
      if (at_end) busy_d = 1'b0;
      else        idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      run_s_q <= '0;
      run_l_q <= '0;
      bst_s_q <= '0;
      bst_l_q <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      run_s_q <= run_s_d;
      run_l_q <= run_l_d;
      bst_s_q <= bst_s_d;
      bst_l_q <= bst_l_d;
    end
  end

  assign best_start = bst_s_q;
  assign best_len   = bst_l_q;
endmodule

// File: rtl/tap_tune_engine.sv
module tap_tune_engine
  import tune_pkg::*;
#(
  parameter int TAP_W    = 8,
  parameter int TAP_LSB  = 16,
  parameter int TICK_DIV = 125000,
  parameter int INHIB_MS = 10,
  parameter int POLL_MS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       bus_mode,
  input  logic             sdr50_tune_req,
  input  logic             cmd_inhibit,
  input  logic             dat_inhibit,
  input  logic [31:0]      clk_ctrl_in,
  input  logic             trial_ack,
  input  logic             rsp_data_avail,
  input  logic             rsp_crc_err,
  input  logic             rsp_tuned_ok,
  output logic             trial_req,
  output logic [5:0]       trial_cmd_idx,
  output logic [2:0]       trial_cmd_flags,
  output logic [11:0]      trial_blk_bytes,
  output logic [31:0]      trial_arg,
  output logic             rst_cmd_line,
  output logic             rst_dat_line,
  output logic [TAP_W-1:0] tap_out,
  output logic [31:0]      clk_ctrl_out,
  output logic             done,
  output logic [TAP_W-1:0] best_start,
  output logic [TAP_W-1:0] best_len,
  output logic             tune_err
);
  localparam int NUM_TAPS = (1 << TAP_W) - 1;
  localparam int MAXMS    = (INHIB_MS > POLL_MS) ? INHIB_MS : POLL_MS;
  localparam int MSW      = $clog2(MAXMS + 1);

  tune_st_e         st_q, st_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             pass_q, pass_d, conf_q, conf_d;
  logic             done_q, done_d, err_q, err_d;
  logic [MSW-1:0]   ms_q, ms_d;
  logic             tick, tick_clr, map_clr, map_wr, scan_go, scan_fin;
  logic [NUM_TAPS-1:0] pass_map;
  logic [TAP_W-1:0] win_start, win_len, fin_tap;
  logic [TAP_W+1:0] len_x3;
  logic             tune_ok, trial_good;

  tune_ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  tune_result_map #(.N(NUM_TAPS), .IW(TAP_W)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(map_clr), .wr_en(map_wr),
    .wr_idx(tap_q), .wr_val(pass_q), .map(pass_map)
  );

  tune_window_search #(.N(NUM_TAPS), .W(TAP_W)) u_search (
    .clk(clk), .rst_n(rst_n), .go(scan_go), .map(pass_map),
    .fin(scan_fin), .best_start(win_start), .best_len(win_len)
  );

  assign tune_ok    = (bus_mode == MODE_SDR104) ||
                      ((bus_mode == MODE_SDR50) && sdr50_tune_req);
  assign trial_good = rsp_data_avail && !rsp_crc_err && rsp_tuned_ok;
  assign len_x3     = {2'b00, win_len} + {1'b0, win_len, 1'b0};
  assign fin_tap    = win_start + len_x3[TAP_W+1:2];

  always_comb begin
    st_d    = st_q;
    tap_d   = tap_q;
    pass_d  = pass_q;
    conf_d  = conf_q;
    done_d  = 1'b0;
    err_d   = err_q;
    map_clr = 1'b0;
    map_wr  = 1'b0;
    scan_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          err_d = 1'b0;
          if (tune_ok) begin
            map_clr = 1'b1;
            tap_d   = '0;
            conf_d  = 1'b0;
            st_d    = ST_INH;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_INH: begin
        if (!cmd_inhibit && !dat_inhibit) begin
          st_d = ST_ACK;
        end else if (ms_q == MSW'(INHIB_MS)) begin
          pass_d = 1'b0;
          st_d   = ST_NEXT;
        end
      end
      ST_ACK: begin
        if (trial_ack) begin
          pass_d = trial_good;
          st_d   = trial_good ? ST_NEXT : ST_LRST;
        end else if (ms_q == MSW'(POLL_MS)) begin
          pass_d = 1'b0;
          st_d   = ST_LRST;
        end
      end
      ST_LRST: st_d = ST_NEXT;
      ST_NEXT: begin
        if (conf_q) begin
          err_d  = !pass_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          map_wr = 1'b1;
          if (tap_q == TAP_W'(NUM_TAPS - 1)) begin
            scan_go = 1'b1;
            st_d    = ST_SCAN;
          end else begin
            tap_d = tap_q + 1'b1;
            st_d  = ST_INH;
          end
        end
      end
      ST_SCAN: if (scan_fin) st_d = ST_PLACE;
      ST_PLACE: begin
        tap_d  = fin_tap;
        conf_d = 1'b1;
        st_d   = ST_INH;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // every state change restarts the millisecond base
  assign tick_clr = (st_d != st_q);

  always_comb begin
    ms_d = ms_q;
    if (tick_clr)                          ms_d = '0;
    else if (tick && ms_q != MSW'(MAXMS))  ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tap_q  <= '0;
      pass_q <= 1'b0;
      conf_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ms_q   <= '0;
    end else begin
      st_q   <= st_d;
      tap_q  <= tap_d;
      pass_q <= pass_d;
      conf_q <= conf_d;
      done_q <= done_d;
      err_q  <= err_d;
      ms_q   <= ms_d;
    end
  end

  always_comb begin
    clk_ctrl_out = clk_ctrl_in;
    clk_ctrl_out[TAP_LSB +: TAP_W] = tap_q;
  end

  assign trial_req       = (st_q == ST_ACK);
  assign rst_cmd_line    = (st_q == ST_LRST);
  assign rst_dat_line    = (st_q == ST_LRST);
  assign trial_cmd_idx   = TUNE_CMD_IDX;
  assign trial_cmd_flags = TUNE_CMD_FLAGS;
  assign trial_blk_bytes = TUNE_BLK_BYTES;
  assign trial_arg       = '0;
  assign tap_out         = tap_q;
  assign done            = done_q;
  assign tune_err        = err_q;
  assign best_start      = win_start;
  assign best_len        = win_len;
endmodule

// File: rtl/tap_tune_checker.sv
module tap_tune_checker #(
  parameter int TAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_inhibit,
  input logic             dat_inhibit,
  input logic             trial_req,
  input logic             rst_cmd_line,
  input logic             rst_dat_line,
  input logic [TAP_W-1:0] tap_out,
  input logic             done,
  input logic [TAP_W-1:0] best_len
);
  // R4: a request only follows a cycle with both inhibits clear
  a_r4_req_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trial_req) |-> $past(!cmd_inhibit && !dat_inhibit));

  // R7: a line reset only follows a pending request
  a_r7_rst_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_cmd_line) |-> $past(trial_req));

  // R7: line resets last one cycle and never overlap a new request
  a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dat_line |=> (!rst_dat_line && !trial_req));

  // R2: tap is held for the whole trial
  a_r2_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> $stable(tap_out));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a one-tap run is never reported
  a_r8_no_single_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_len != TAP_W'(1)));
endmodule

bind tap_tune_engine tap_tune_checker #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
  .trial_req(trial_req), .rst_cmd_line(rst_cmd_line), .rst_dat_line(rst_dat_line),
  .tap_out(tap_out), .done(done), .best_len(best_len)
);

// File: tb/sim_tap_tune_engine.sv
module sim_tap_tune_engine;
  localparam int NT = 255;

  logic        clk = 1'b0;
  logic        rst_n, start, sdr50_tune_req, cmd_inhibit, dat_inhibit;
  logic [2:0]  bus_mode;
  logic [31:0] clk_ctrl_in, clk_ctrl_out, trial_arg;
  logic        trial_ack, rsp_data_avail, rsp_crc_err, rsp_tuned_ok;
  logic        trial_req, rst_cmd_line, rst_dat_line, done, tune_err;
  logic [5:0]  trial_cmd_idx;
  logic [2:0]  trial_cmd_flags;
  logic [11:0] trial_blk_bytes;
  logic [7:0]  tap_out, best_start, best_len;

  always #4 clk = ~clk;  // 125 MHz

  tap_tune_engine #(.TICK_DIV(4)) u0 (.*);

  int checks = 0, errors = 0;
  logic [NT-1:0] pmap;
  logic rsp_en, force_conf_fail;
  int trial_seen, order_err, cmd_err, rst_cnt, req_cnt;

  // each entry: three runs (start,len), then expected start, len, final tap, err
  localparam int VT[7][10] = '{
    '{10, 20, 100, 30, 200, 5, 100, 30, 122, 0},
    '{ 5,  8,  50,  8,   0, 0,   5,  8,  11, 0},
    '{ 3,  1,   7,  1,   9, 1,   0,  0,   0, 1},
    '{ 0,255,   0,  0,   0, 0,   0,255, 191, 0},
    '{240,15,   0,  2,   0, 0, 240, 15, 251, 0},
    '{ 1,  1,  20,  2,  60, 1,  20,  2,  21, 0},
    '{ 0,  3,   4,  4,   0, 0,   4,  4,   7, 0}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_search(input logic [NT-1:0] m, output int bs, output int bl);
    bs = 0; bl = 0;
    for (int s = 0; s < NT; s++) begin
      if (m[s] && (s == 0 || !m[s-1])) begin
        int l = 0;
        while (s + l < NT && m[s+l]) l++;
        if (l > 1 && l > bl) begin bs = s; bl = l; end
      end
    end
  endfunction

  // command/data engine model
  initial begin
    int dly = 0;
    trial_ack = 0; rsp_data_avail = 0; rsp_crc_err = 0; rsp_tuned_ok = 0;
    forever begin
      @(negedge clk);
      if (trial_ack) begin
        trial_ack = 0;
      end else if (trial_req && rsp_en) begin
        if (dly == 2) begin
          logic good;
          dly = 0;
          if (trial_seen < NT && int'(tap_out) != trial_seen) order_err++;
          if (trial_cmd_idx != 6'd19 || trial_cmd_flags != 3'b111 ||
              trial_blk_bytes != 12'd64 || trial_arg != 32'd0) cmd_err++;
          good = (trial_seen >= NT && force_conf_fail) ? 1'b0 : pmap[tap_out];
          rsp_data_avail = 1; rsp_crc_err = 0; rsp_tuned_ok = 1;
          if (!good) begin
            case (tap_out % 3)
              0: rsp_data_avail = 0;
              1: rsp_crc_err = 1;
              default: rsp_tuned_ok = 0;
            endcase
          end
          trial_ack = 1;
          trial_seen++;
        end else dly++;
      end else dly = 0;
    end
  end

  initial begin
    logic req_prev = 0;
    forever begin
      @(negedge clk);
      if (rst_cmd_line && rst_dat_line) rst_cnt++;
      if (trial_req && !req_prev) req_cnt++;
      req_prev = trial_req;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run_and_wait(input string tag);
    int guard = 0;
    trial_seen = 0; order_err = 0; cmd_err = 0; rst_cnt = 0; req_cnt = 0;
    pulse_start();
    while (!done && guard < 40000) begin @(negedge clk); guard++; end
    chk({tag, " R10 done seen"}, int'(done), 1);
  endtask

  function automatic logic [NT-1:0] build(input int v);
    logic [NT-1:0] m = '0;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < VT[v][2*r+1]; k++) m[VT[v][2*r] + k] = 1'b1;
    return m;
  endfunction

  initial begin
    int rs, rl, nfail;
    rst_n = 0; start = 0; bus_mode = 3'd3; sdr50_tune_req = 0;
    cmd_inhibit = 0; dat_inhibit = 0; clk_ctrl_in = 32'hA5C3_5A3C;
    rsp_en = 1; force_conf_fail = 0; pmap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 tap", int'(tap_out), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 req", int'(trial_req), 0);
    chk("R11 err", int'(tune_err), 0);
    chk("R11 line rst", int'(rst_cmd_line | rst_dat_line), 0);

    for (int v = 0; v < 7; v++) begin
      pmap = build(v);
      bus_mode = (v == 1) ? 3'd2 : 3'd3;
      sdr50_tune_req = (v == 1);
      ref_search(pmap, rs, rl);
      chk("R8 table vs reference start", VT[v][6], rs);
      chk("R8 table vs reference len", VT[v][7], rl);
      run_and_wait("vec");
      chk("R8 best_start", int'(best_start), VT[v][6]);
      chk("R8 best_len", int'(best_len), VT[v][7]);
      chk("R9 final tap", int'(tap_out), VT[v][8]);
      chk("R10 tune_err", int'(tune_err), VT[v][9]);
      chk("R2 trial count", trial_seen, NT + 1);
      chk("R2 tap order", order_err, 0);
      chk("R5 trial fields", cmd_err, 0);
      nfail = NT - $countones(pmap) + VT[v][9];
      chk("R6 R7 line resets per failing trial", rst_cnt, nfail);
    end
    // R3 field placement with final tap 7 from last vector
    chk("R3 clk_ctrl_out", int'(clk_ctrl_out), int'({8'hA5, 8'd7, 16'h5A3C}));

    // R1 modes that do not tune
    begin
      logic [2:0] nm[3] = '{3'd0, 3'd2, 3'd4};
      for (int i = 0; i < 3; i++) begin
        bus_mode = nm[i]; sdr50_tune_req = 0; req_cnt = 0;
        pulse_start();
        chk("R1 done next cycle", int'(done), 1);
        repeat (4) @(negedge clk);
        chk("R1 tap unchanged", int'(tap_out), 7);
        chk("R1 no request", req_cnt, 0);
      end
    end

    // R10 confirm failure with a good window
    pmap = build(0); bus_mode = 3'd3; force_conf_fail = 1;
    run_and_wait("conf");
    chk("R10 confirm fail err", int'(tune_err), 1);
    chk("R9 final tap kept", int'(tap_out), 122);
    force_conf_fail = 0;

    // R4 inhibit held: every trial times out, no request, no line reset
    cmd_inhibit = 1;
    run_and_wait("inh");
    chk("R4 no request", req_cnt, 0);
    chk("R4 no line reset", rst_cnt, 0);
    chk("R9 empty window tap", int'(tap_out), 0);
    chk("R10 err after inhibit", int'(tune_err), 1);
    cmd_inhibit = 0;

    // R7 poll timeout: no ack, one line reset per trial
    rsp_en = 0; pmap = '1;
    run_and_wait("poll");
    chk("R7 resets on timeout", rst_cnt, NT + 1);
    chk("R8 no window", int'(best_len), 0);
    chk("R10 err after timeout", int'(tune_err), 1);
    rsp_en = 1;

    summary();
    $finish;
  end
endmodule